// File: doc/BRIEF.md
# UART Host Register Interface

This block sits between a processor bus and the serial engine of a classic eight-bit UART. It selects one of eight byte-wide registers through a three-bit offset. That offset either follows the address pins directly or is held in a latch controlled by an active-low address strobe. An access only counts when three chip-select pins all agree, and they are of mixed polarity. Reads and writes can each be requested by an active-high or an active-low strobe. A bank bit in the line control register remaps the two lowest offsets onto the baud-rate divisor bytes.

Writes are taken once per access, on the first clock where the write enable is seen. A data write raises a single-cycle load pulse to the transmitter. A data read raises a single-cycle acknowledge pulse to the receiver. Status from the shifters and the interrupt logic enters on input ports, and software sees it through the read-only offsets.

The master reset clears the control state. It spares the transmit holding byte and both divisor bytes, so a programmed baud rate survives a reset.

Top module: `uart_host_regs`

## Requirements
- R1: An access is qualified only when sel0_i=1, sel1_i=1 and sel2_n_i=0; under any other combination a write changes nothing and rdata_o reads 0.
- R2: While adstb_n_i=0 the offset follows addr_i. While adstb_n_i=1 the offset is the addr_i value present at the last clock edge where adstb_n_i was 0.
- R3: Read enable is qualified select AND (rd_i=1 OR rd_n_i=0). While it is true, rdata_o shows the selected register; otherwise rdata_o is 0.
- R4: Write enable is qualified select AND (wr_i=1 OR wr_n_i=0). Data is stored only at the first clock edge of each enabled interval, even if the enable and wdata_i are held longer.
- R5: The bank bit is bit 7 of line control (offset 3). When it is 1, offset 0 is the low divisor byte and offset 1 is the high divisor byte, and divisor_o = {high, low}. When it is 0, offset 0 is receive/transmit data and offset 1 is interrupt enable.
- R6: Offsets: 0 data, 1 interrupt enable (bits 3:0 kept, 7:4 read 0), 2 interrupt identification, 3 line control, 4 modem control (bits 4:0 kept, 7:5 read 0), 5 line status, 6 modem status, 7 scratch. A data read returns rx_data_i.
- R7: A data write with the bank bit 0 sets thr_o to the written byte and raises tx_load_o for exactly the one cycle after the write edge.
- R8: A data read with the bank bit 0 raises rx_ack_o for exactly the one cycle after the first clock edge of the read.
- R9: After mst_rst, interrupt enable, line control, modem control and scratch read 0, and interrupt identification reads 0x01. When not in reset, interrupt identification is {4'b0, int_id_i} as sampled at the previous clock edge.
- R10: mst_rst leaves thr_o and both divisor bytes unchanged, and no write is taken while it is asserted.
- R11: Writes to offsets 2, 5 and 6 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mst_rst | input | 1 | Master reset, active high, synchronous |
| addr_i | input | 3 | Register offset |
| adstb_n_i | input | 1 | Address strobe, low = transparent |
| sel0_i | input | 1 | Chip select, active high |
| sel1_i | input | 1 | Chip select, active high |
| sel2_n_i | input | 1 | Chip select, active low |
| rd_i | input | 1 | Read strobe, active high |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_i | input | 1 | Write strobe, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| wdata_i | input | 8 | Write data |
| rx_data_i | input | 8 | Received byte from the receiver |
| lstat_i | input | 8 | Line status from the serial engine |
| mstat_i | input | 8 | Modem status from the serial engine |
| int_id_i | input | 4 | Interrupt identification code from the priority logic |
| rdata_o | output | 8 | Read data, 0 when no read is enabled |
| thr_o | output | 8 | Transmit holding byte |
| divisor_o | output | 16 | Baud divisor {high, low} |
| lctl_o | output | 8 | Line control register |
| ien_o | output | 4 | Interrupt enable bits |
| mctl_o | output | 5 | Modem control bits |
| tx_load_o | output | 1 | One-cycle transmit load pulse |
| rx_ack_o | output | 1 | One-cycle receive acknowledge pulse |

## Verification
A stale or wrong offset latch, edge tracker or bank bit shows up on rdata_o in the same cycle a read is asserted. The configuration ports and the tx_load_o and rx_ack_o pulses expose it one cycle after the offending edge. A lost or doubled write edge shows as an extra or missing pulse, or as a register that holds a later byte instead of the first one. A reset that reaches too far appears as a divisor or holding byte that changes across mst_rst.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        OFF_DATA  = 3'd0,
        OFF_IEN   = 3'd1,
        OFF_IID   = 3'd2,
        OFF_LCTL  = 3'd3,
        OFF_MCTL  = 3'd4,
        OFF_LSTAT = 3'd5,
        OFF_MSTAT = 3'd6,
        OFF_SCR   = 3'd7
    } reg_off_e;
endpackage

// File: rtl/uart_addr_latch.sv
module uart_addr_latch #(
    parameter int AW = uart_host_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb_n_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] lat_d, lat_q;

    always_comb begin
        lat_d  = stb_n_i ? lat_q : addr_i;
        addr_o = lat_d;
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= lat_d;
    end

    // R2: with the strobe high across two edges the offset must not move
    p_hold_offset_r2: assert property (@(posedge clk) disable iff (rst)
        (stb_n_i && $past(stb_n_i) && !$past(rst)) |-> $stable(addr_o));
endmodule

// File: rtl/uart_access_ctl.sv
module uart_access_ctl (
    input  logic clk,
    input  logic rst,
    input  logic sel0_i,
    input  logic sel1_i,
    input  logic sel2_n_i,
    input  logic rd_i,
    input  logic rd_n_i,
    input  logic wr_i,
    input  logic wr_n_i,
    output logic rd_en_o,
    output logic rd_first_o,
    output logic wr_first_o
);
    typedef struct packed {
        logic rd_prev;
        logic wr_prev;
    } trk_t;

    trk_t trk_d, trk_q;
    logic chosen, wr_en;

    always_comb begin
        chosen     = sel0_i & sel1_i & ~sel2_n_i;
        rd_en_o    = chosen & (rd_i | ~rd_n_i);
        wr_en      = chosen & (wr_i | ~wr_n_i);
        rd_first_o = rd_en_o & ~trk_q.rd_prev & ~rst;
        wr_first_o = wr_en & ~trk_q.wr_prev & ~rst;
        trk_d.rd_prev = rd_en_o;
        trk_d.wr_prev = wr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) trk_q <= '0;
        else     trk_q <= trk_d;
    end

    // R4: one write edge per enabled interval
    p_single_write_r4: assert property (@(posedge clk) disable iff (rst)
        wr_first_o |=> !wr_first_o);
    // R8: one read edge per enabled interval
    p_single_read_r8: assert property (@(posedge clk) disable iff (rst)
        rd_first_o |=> !rd_first_o);
endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank #(
    parameter int DW     = uart_host_pkg::DATA_W,
    parameter int AW     = uart_host_pkg::ADDR_W,
    parameter int IEN_W  = 4,
    parameter int MCTL_W = 5,
    parameter int IID_W  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   off_i,
    input  logic            rd_en_i,
    input  logic            rd_first_i,
    input  logic            wr_first_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [DW-1:0]   rx_data_i,
    input  logic [DW-1:0]   lstat_i,
    input  logic [DW-1:0]   mstat_i,
    input  logic [IID_W-1:0] iid_i,
    output logic [DW-1:0]   rdata_o,
    output logic [DW-1:0]   thr_o,
    output logic [2*DW-1:0] div_o,
    output logic [DW-1:0]   lctl_o,
    output logic [IEN_W-1:0] ien_o,
    output logic [MCTL_W-1:0] mctl_o,
    output logic            tx_load_o,
    output logic            rx_ack_o
);
    import uart_host_pkg::*;

    localparam logic [DW-1:0] IID_IDLE = DW'(1);

    typedef struct packed {
        logic [IEN_W-1:0]  ien;
        logic [DW-1:0]     lctl;
        logic [MCTL_W-1:0] mctl;
        logic [DW-1:0]     scr;
        logic [DW-1:0]     iid;
        logic              tx_load;
        logic              rx_ack;
    } ctl_t;

    typedef struct packed {
        logic [DW-1:0] thr;
        logic [DW-1:0] dll;
        logic [DW-1:0] dlm;
    } keep_t;

    ctl_t     c_d, c_q;
    keep_t    k_d, k_q;
    logic     bank;
    reg_off_e off;
    logic [DW-1:0] rd_val;

    always_comb begin
        c_d         = c_q;
        k_d         = k_q;
        bank        = c_q.lctl[DW-1];
        off         = reg_off_e'(off_i);
        c_d.iid     = DW'(iid_i);
        c_d.tx_load = 1'b0;
        c_d.rx_ack  = rd_first_i & (off == OFF_DATA) & ~bank;
        if (wr_first_i) begin
            case (off)
                OFF_DATA: begin
                    if (bank) k_d.dll = wdata_i;
                    else begin
                        k_d.thr     = wdata_i;
                        c_d.tx_load = 1'b1;
                    end
                end
                OFF_IEN: begin
                    if (bank) k_d.dlm = wdata_i;
                    else      c_d.ien = wdata_i[IEN_W-1:0];
                end
                OFF_LCTL: c_d.lctl = wdata_i;
                OFF_MCTL: c_d.mctl = wdata_i[MCTL_W-1:0];
                OFF_SCR:  c_d.scr  = wdata_i;
                default:  ;
            endcase
        end

        case (off)
            OFF_DATA:  rd_val = bank ? k_q.dll : rx_data_i;
            OFF_IEN:   rd_val = bank ? k_q.dlm : DW'(c_q.ien);
            OFF_IID:   rd_val = c_q.iid;
            OFF_LCTL:  rd_val = c_q.lctl;
            OFF_MCTL:  rd_val = DW'(c_q.mctl);
            OFF_LSTAT: rd_val = lstat_i;
            OFF_MSTAT: rd_val = mstat_i;
            default:   rd_val = c_q.scr;
        endcase
        rdata_o = rd_en_i ? rd_val : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q     <= '0;
            c_q.iid <= IID_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    always_ff @(posedge clk) k_q <= k_d;

    assign thr_o     = k_q.thr;
    assign div_o     = {k_q.dlm, k_q.dll};
    assign lctl_o    = c_q.lctl;
    assign ien_o     = c_q.ien;
    assign mctl_o    = c_q.mctl;
    assign tx_load_o = c_q.tx_load;
    assign rx_ack_o  = c_q.rx_ack;

    // R9: control registers come out of reset cleared
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ien_o == '0 && lctl_o == '0 && mctl_o == '0));
    // R10: divisor untouched by reset
    p_div_kept_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> $stable(div_o));
    // R7: load pulse lasts one cycle
    p_load_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        tx_load_o |=> !tx_load_o);
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs #(
    parameter int DW     = uart_host_pkg::DATA_W,
    parameter int AW     = uart_host_pkg::ADDR_W,
    parameter int IEN_W  = 4,
    parameter int MCTL_W = 5,
    parameter int IID_W  = 4
) (
    input  logic              clk,
    input  logic              mst_rst,
    input  logic [AW-1:0]     addr_i,
    input  logic              adstb_n_i,
    input  logic              sel0_i,
    input  logic              sel1_i,
    input  logic              sel2_n_i,
    input  logic              rd_i,
    input  logic              rd_n_i,
    input  logic              wr_i,
    input  logic              wr_n_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [DW-1:0]     rx_data_i,
    input  logic [DW-1:0]     lstat_i,
    input  logic [DW-1:0]     mstat_i,
    input  logic [IID_W-1:0]  int_id_i,
    output logic [DW-1:0]     rdata_o,
    output logic [DW-1:0]     thr_o,
    output logic [2*DW-1:0]   divisor_o,
    output logic [DW-1:0]     lctl_o,
    output logic [IEN_W-1:0]  ien_o,
    output logic [MCTL_W-1:0] mctl_o,
    output logic              tx_load_o,
    output logic              rx_ack_o
);
    logic [AW-1:0] off;
    logic rd_en, rd_first, wr_first;

    uart_addr_latch #(.AW(AW)) u_alat (
        .clk(clk), .rst(mst_rst), .stb_n_i(adstb_n_i),
        .addr_i(addr_i), .addr_o(off)
    );

    uart_access_ctl u_acc (
        .clk(clk), .rst(mst_rst),
        .sel0_i(sel0_i), .sel1_i(sel1_i), .sel2_n_i(sel2_n_i),
        .rd_i(rd_i), .rd_n_i(rd_n_i), .wr_i(wr_i), .wr_n_i(wr_n_i),
        .rd_en_o(rd_en), .rd_first_o(rd_first), .wr_first_o(wr_first)
    );

    uart_reg_bank #(
        .DW(DW), .AW(AW), .IEN_W(IEN_W), .MCTL_W(MCTL_W), .IID_W(IID_W)
    ) u_bank (
        .clk(clk), .rst(mst_rst), .off_i(off),
        .rd_en_i(rd_en), .rd_first_i(rd_first), .wr_first_i(wr_first),
        .wdata_i(wdata_i), .rx_data_i(rx_data_i),
        .lstat_i(lstat_i), .mstat_i(mstat_i), .iid_i(int_id_i),
        .rdata_o(rdata_o), .thr_o(thr_o), .div_o(divisor_o),
        .lctl_o(lctl_o), .ien_o(ien_o), .mctl_o(mctl_o),
        .tx_load_o(tx_load_o), .rx_ack_o(rx_ack_o)
    );

    // R8: an acknowledge only follows an enabled read
    p_ack_after_read_r8: assert property (@(posedge clk) disable iff (mst_rst)
        rx_ack_o |-> $past(rd_en));
    // R1: a load pulse only follows a qualified select
    p_load_needs_sel_r1: assert property (@(posedge clk) disable iff (mst_rst)
        tx_load_o |-> $past(sel0_i && sel1_i && !sel2_n_i));
endmodule

// File: tb/sim_uart_host_regs.sv
`timescale 1ns/1ps
module sim_uart_host_regs;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic [2:0] addr = 3'd0;
    logic       stbn = 1'b0, s0 = 1'b1, s1 = 1'b1, s2n = 1'b0;
    logic       rd = 1'b0, rdn = 1'b1, wr = 1'b0, wrn = 1'b1;
    logic [7:0] wdata = 8'h00, rxd = 8'hC3, lst = 8'h60, mst = 8'hB0;
    logic [3:0] iid = 4'h1;

    logic [7:0]  rdata, thr, lctl;
    logic [15:0] div;
    logic [3:0]  ien;
    logic [4:0]  mctl;
    logic        txl, ack;

    uart_host_regs u0 (
        .clk(clk), .mst_rst(rst), .addr_i(addr), .adstb_n_i(stbn),
        .sel0_i(s0), .sel1_i(s1), .sel2_n_i(s2n),
        .rd_i(rd), .rd_n_i(rdn), .wr_i(wr), .wr_n_i(wrn),
        .wdata_i(wdata), .rx_data_i(rxd), .lstat_i(lst), .mstat_i(mst),
        .int_id_i(iid), .rdata_o(rdata), .thr_o(thr), .divisor_o(div),
        .lctl_o(lctl), .ien_o(ien), .mctl_o(mctl),
        .tx_load_o(txl), .rx_ack_o(ack)
    );

    int total = 0, bad = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   m_alat = 0;
    bit   m_wprev = 0, m_rprev = 0, m_txl = 0, m_ack = 0;
    int   m_ien = 0, m_lctl = 0, m_mctl = 0, m_scr = 0, m_iid = 1;
    int   m_thr = 0, m_dll = 0, m_dlm = 0;
    bit   thr_known = 0, div_known = 0;
    bit   started = 0;

    function automatic int eff_off();
        return stbn ? m_alat : int'(addr);
    endfunction

    function automatic int model_rdata();
        bit sel = s0 && s1 && !s2n;
        bit ren = sel && (rd || !rdn);
        bit bk  = m_lctl[7];
        if (!ren) return 0;
        case (eff_off())
            0: return bk ? m_dll : int'(rxd);
            1: return bk ? m_dlm : m_ien;
            2: return m_iid;
            3: return m_lctl;
            4: return m_mctl;
            5: return int'(lst);
            6: return int'(mst);
            default: return m_scr;
        endcase
    endfunction

    always @(posedge clk) begin
        bit sel, ren, wen, wf, rf, bk;
        int o;
        started = 1;
        sel = s0 && s1 && !s2n;
        ren = sel && (rd || !rdn);
        wen = sel && (wr || !wrn);
        o   = eff_off();
        if (rst) begin
            m_alat = 0; m_wprev = 0; m_rprev = 0; m_txl = 0; m_ack = 0;
            m_ien = 0; m_lctl = 0; m_mctl = 0; m_scr = 0; m_iid = 1;
        end else begin
            wf = wen && !m_wprev;
            rf = ren && !m_rprev;
            bk = m_lctl[7];
            m_txl = 0;
            m_ack = rf && (o == 0) && !bk;
            m_iid = int'(iid);
            if (wf) begin
                case (o)
                    0: if (bk) begin m_dll = wdata; div_known = 1; end
                       else begin m_thr = wdata; thr_known = 1; m_txl = 1; end
                    1: if (bk) m_dlm = wdata; else m_ien = wdata & 8'h0F;
                    3: m_lctl = wdata;
                    4: m_mctl = wdata & 8'h1F;
                    7: m_scr = wdata;
                    default: ;
                endcase
            end
            if (!stbn) m_alat = int'(addr);
            m_wprev = wen;
            m_rprev = ren;
        end
    end

    // compare every cycle, late in the low phase
    always @(negedge clk) begin
        #8;
        if (started) begin
            chk("R3 rdata", rdata, model_rdata());
            chk("R7 tx_load", txl, m_txl);
            chk("R8 rx_ack", ack, m_ack);
            chk("R5 lctl", lctl, m_lctl);
            chk("R6 ien", ien, m_ien);
            chk("R6 mctl", mctl, m_mctl);
            if (thr_known) chk("R7 thr", thr, m_thr);
            if (div_known) chk("R5 divisor", div, {m_dlm[7:0], m_dll[7:0]});
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle();
        rd = 0; rdn = 1; wr = 0; wrn = 1;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input bit use_n);
        @(negedge clk);
        addr = a; wdata = d;
        if (use_n) wrn = 0; else wr = 1;
        @(negedge clk);
        idle();
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp,
                          input string tag, input bit use_n);
        @(negedge clk);
        addr = a;
        if (use_n) rdn = 0; else rd = 1;
        #5 chk(tag, rdata, exp);
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R9 reset values
        rd_chk(3'd1, 8'h00, "R9 ien reset", 0);
        rd_chk(3'd3, 8'h00, "R9 lctl reset", 0);
        rd_chk(3'd4, 8'h00, "R9 mctl reset", 1);
        rd_chk(3'd7, 8'h00, "R9 scratch reset", 0);
        rd_chk(3'd2, 8'h01, "R9 iid reset", 0);
        // R3/R4 both strobe polarities
        wr_reg(3'd3, 8'h03, 0);
        rd_chk(3'd3, 8'h03, "R4 lctl write", 1);
        wr_reg(3'd7, 8'hA5, 1);
        rd_chk(3'd7, 8'hA5, "R4 scratch via wr_n", 0);
        // R6 unimplemented bits
        wr_reg(3'd1, 8'hFF, 0);
        rd_chk(3'd1, 8'h0F, "R6 ien upper bits", 0);
        wr_reg(3'd4, 8'hFF, 0);
        rd_chk(3'd4, 8'h1F, "R6 mctl upper bits", 0);
        rd_chk(3'd5, lst, "R6 line status", 0);
        rd_chk(3'd6, mst, "R6 modem status", 0);
        // R7 transmit load
        wr_reg(3'd0, 8'h5A, 0);
        chk("R7 thr value", thr, 8'h5A);
        // R5 divisor bank
        wr_reg(3'd3, 8'h83, 0);
        wr_reg(3'd0, 8'h34, 0);
        wr_reg(3'd1, 8'h12, 1);
        rd_chk(3'd0, 8'h34, "R5 divisor low", 0);
        rd_chk(3'd1, 8'h12, "R5 divisor high", 0);
        chk("R5 divisor port", div, 16'h1234);
        chk("R5 thr untouched", thr, 8'h5A);
        wr_reg(3'd3, 8'h03, 0);
        rd_chk(3'd0, rxd, "R8 data read", 0);
        rd_chk(3'd1, 8'h0F, "R5 ien back", 0);
        // R1 select qualification
        s0 = 0; wr_reg(3'd7, 8'h11, 0); s0 = 1;
        s2n = 1; wr_reg(3'd7, 8'h22, 1); s2n = 0;
        rd_chk(3'd7, 8'hA5, "R1 write ignored", 0);
        s1 = 0; rd_chk(3'd7, 8'h00, "R1 read gated", 0); s1 = 1;
        // R11 read-only offsets
        wr_reg(3'd2, 8'hFF, 0);
        wr_reg(3'd5, 8'hFF, 0);
        wr_reg(3'd6, 8'hFF, 1);
        rd_chk(3'd2, 8'h01, "R11 iid", 0);
        rd_chk(3'd3, 8'h03, "R11 lctl", 0);
        rd_chk(3'd7, 8'hA5, "R11 scratch", 0);
        rd_chk(3'd1, 8'h0F, "R11 ien", 0);
        // R4 held write takes the first byte only
        @(negedge clk); addr = 3'd7; wdata = 8'h66; wr = 1;
        @(negedge clk); wdata = 8'h77;
        repeat (3) @(negedge clk);
        idle();
        rd_chk(3'd7, 8'h66, "R4 first edge only", 0);
        // R2 address latch
        @(negedge clk); addr = 3'd3; stbn = 0;
        @(negedge clk); stbn = 1; addr = 3'd7;
        rd_chk(3'd7, 8'h03, "R2 latched offset", 0);
        wr_reg(3'd1, 8'h0C, 0);
        stbn = 0;
        rd_chk(3'd3, 8'h0C, "R2 write to latched offset", 0);
        wr_reg(3'd3, 8'h03, 0);
        // R9 interrupt id follows input
        iid = 4'h6;
        repeat (2) @(negedge clk);
        rd_chk(3'd2, 8'h06, "R9 iid follow", 0);
        // R10 reset keeps data buffers, blocks writes
        @(negedge clk); rst = 1; addr = 3'd0; wdata = 8'hEE; wr = 1;
        repeat (2) @(negedge clk);
        idle(); rst = 0;
        chk("R10 thr kept", thr, 8'h5A);
        chk("R10 divisor kept", div, 16'h1234);
        rd_chk(3'd3, 8'h00, "R9 lctl after reset", 0);
        wr_reg(3'd3, 8'h80, 0);
        rd_chk(3'd0, 8'h34, "R10 divisor low kept", 0);
        rd_chk(3'd1, 8'h12, "R10 divisor high kept", 1);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule